// File: doc/BRIEF.md
# USB Endpoint-0 Control-Write Sequencer

This block steps endpoint 0 of a USB device controller through a control-write transfer. A packet layer hands it decoded events: token arrivals (SETUP, OUT, IN), a host ACK, and the bytes of a received data packet. At the end of each packet it also gives the data PID and a CRC verdict. For each event the block decides what the device answers: ACK, NAK, a zero-length DATA1 packet, or nothing. It holds the eight-byte request where the CPU can read it, and it buffers each accepted data-stage payload for the CPU to read.

Progress from one stage to the next depends on the CPU. After a valid request arrives, the block raises a setup interrupt and NAKs all traffic until the CPU acknowledges the request. In the data stage it accepts one payload at a time and NAKs further OUT packets until the CPU has read every byte of that payload. It NAKs IN tokens until the CPU writes an end-of-processing command. After that command it answers IN with the zero-length status packet. When the host ACKs that packet, the block raises a status interrupt and returns to idle.

Top module: `usb_ep0_wr_seq`

## Requirements
- R1: While `rst` is high and on the cycle after, `hs_vld`, `irq_flags`, `data_ready`, `data_count`, `rd_data` and all request fields are zero.
- R2: A SETUP token followed by an 8-byte packet with a valid CRC and DATA0 PID (`rx_pid_data1`=0) produces `hs_vld` with `hs_kind`=0 (ACK) one cycle after `rx_pkt_end`. In that same cycle the request fields are loaded little-endian: byte 0 goes to `req_type`, byte 1 to `req_code`, bytes 2-3 to `req_value`, bytes 4-5 to `req_index` and bytes 6-7 to `req_length`. Also in that cycle `irq_flags[0]` (setup) is set.
- R3: A packet with a bad CRC gets no handshake and causes no change of stage, fields or buffer. The same holds for a setup packet whose length is not 8 or whose PID is DATA1, and for an OUT packet longer than `MAX_PKT`.
- R4: Until the CPU pulses `cpu_setup_ack`, a valid OUT packet and an IN token are each answered with `hs_kind`=1 (NAK).
- R5: In the data stage, the first valid OUT packet must carry DATA1, and the expected PID then alternates. A packet with the expected PID is ACKed and sets `data_ready`, with `data_count` equal to its length. Each `cpu_rd` pulse then returns the next payload byte in arrival order on `rd_data` one cycle later.
- R6: `data_ready` clears with the read of the last byte. An OUT token that arrives while `data_ready` is high, including in the same cycle as that final read, has its packet NAKed, and the buffer is unchanged.
- R7: An OUT packet whose PID repeats the previous one is ACKed but its data is discarded (`data_ready` stays 0 and the expected PID does not change).
- R8: An IN token in the data stage is answered with NAK and sets `irq_flags[2]` (early status).
- R9: `cpu_eop_wr` with `cpu_eop_bit`=0 in the data stage moves to the status stage. With `cpu_eop_bit`=1 the write has no effect.
- R10: In the status stage every IN token is answered with `hs_kind`=2 (zero-length DATA1). A host ACK after that packet sets `irq_flags[1]` (status) and returns to idle, where IN tokens get no handshake.
- R11: A SETUP token in any stage abandons the transfer, clears `data_ready` and `data_count`, and restarts the setup stage.
- R12: An interrupt flag stays set until the CPU writes 1 to its bit of `irq_clr`. If a set and a clear fall in the same cycle, the set wins.
- R13: A zero-length OUT packet with the expected PID is ACKed and flips the expected PID, leaves `data_ready` at 0 and sets `data_count` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_setup | input | 1 | SETUP token to endpoint 0 (pulse) |
| tok_out | input | 1 | OUT token to endpoint 0 (pulse) |
| tok_in | input | 1 | IN token to endpoint 0 (pulse) |
| rx_ack | input | 1 | Host ACK handshake received (pulse) |
| rx_byte_vld | input | 1 | Data packet payload byte valid |
| rx_byte | input | 8 | Payload byte |
| rx_pkt_end | input | 1 | End of data packet (pulse, never with a byte) |
| rx_pid_data1 | input | 1 | PID of ending packet: 1 = DATA1, 0 = DATA0 |
| rx_crc_ok | input | 1 | CRC of ending packet valid |
| hs_vld | output | 1 | Response request (one-cycle pulse) |
| hs_kind | output | 2 | 0 ACK, 1 NAK, 2 zero-length DATA1 |
| irq_flags | output | 3 | Bit 0 setup, bit 1 status, bit 2 early status |
| irq_clr | input | 3 | Write-1-to-clear strobes for `irq_flags` |
| req_type | output | 8 | Request byte 0 |
| req_code | output | 8 | Request byte 1 |
| req_value | output | 16 | Request bytes 2-3 |
| req_index | output | 16 | Request bytes 4-5 |
| req_length | output | 16 | Request bytes 6-7 |
| cpu_setup_ack | input | 1 | CPU has taken the request (pulse) |
| data_ready | output | 1 | Unread data-stage payload present |
| data_count | output | CNT_W (4) | Byte count of the last accepted payload |
| cpu_rd | input | 1 | Read one payload byte (pulse) |
| rd_data | output | 8 | Byte read, valid one cycle after `cpu_rd` |
| cpu_eop_wr | input | 1 | End-of-processing register write strobe |
| cpu_eop_bit | input | 1 | Endpoint-0 bit value of that write |

## Verification
Two pairs of events can land in the same cycle, and the bench makes each pair coincide on purpose. In the first, the CPU's final `cpu_rd` of a payload falls in the same cycle as the next OUT token. The sampled buffer state at the token edge then decides between acceptance and NAK. The bench expects NAK for that packet and expects `data_ready` and `data_count` to show the buffer untouched. In the second, an IN token in the data stage sets the early-status flag while the CPU's clear strobe for that same bit arrives. The flag must remain set. A behavioural model in the bench computes every handshake, flag, field and read byte and compares them with the design on every clock.

// File: rtl/usb_ep0_pkg.sv
`timescale 1ns/1ps
package usb_ep0_pkg;
  localparam int REQ_BYTES = 8;
  localparam int REQ_IDX_W = $clog2(REQ_BYTES);
  localparam int IRQ_N     = 3;
  localparam int IRQ_SETUP = 0;
  localparam int IRQ_STAT  = 1;
  localparam int IRQ_EARLY = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP_RX, ST_WAIT_CPU, ST_DATA, ST_STATUS, ST_ZLP_SENT
  } stage_e;

  typedef enum logic [1:0] {
    HS_ACK = 2'd0, HS_NAK = 2'd1, HS_ZLP1 = 2'd2
  } hs_e;

  typedef enum logic [1:0] {TK_NONE, TK_SETUP, TK_OUT} tok_e;

  typedef struct packed {
    logic [15:0] length;
    logic [15:0] index;
    logic [15:0] value;
    logic [7:0]  code;
    logic [7:0]  rtype;
  } req_t;
endpackage

// File: rtl/usb_ep0_req_capture.sv
`timescale 1ns/1ps
module usb_ep0_req_capture
  import usb_ep0_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_we,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [7:0]       byte_in,
  input  logic             commit,
  output req_t             req
);
  logic [7:0]             stg [REQ_BYTES];
  logic [8*REQ_BYTES-1:0] stg_flat;

  always_ff @(posedge clk) begin
    if (byte_we && byte_idx < CNT_W'(REQ_BYTES))
      stg[byte_idx[REQ_IDX_W-1:0]] <= byte_in;
  end

  for (genvar g = 0; g < REQ_BYTES; g++) begin : g_flat
    assign stg_flat[8*g +: 8] = stg[g];
  end

  always_ff @(posedge clk) begin
    if (rst)         req <= '0;
    else if (commit) req <= req_t'(stg_flat);
  end
endmodule

// File: rtl/usb_ep0_rx_buffer.sv
`timescale 1ns/1ps
module usb_ep0_rx_buffer #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_idx,
  input  logic [7:0]       wr_byte,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_len,
  input  logic             rd_req,
  output logic [7:0]       rd_data,
  output logic             ready,
  output logic [CNT_W-1:0] count
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] rd_ptr;
  logic             rd_fire;

  assign rd_fire = rd_req && ready && !flush;

  always_ff @(posedge clk) begin
    if (wr_en && wr_idx < CNT_W'(DEPTH))
      mem[wr_idx[ADDR_W-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_fire) rd_data <= mem[rd_ptr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      ready  <= 1'b0;
      count  <= '0;
    end else if (commit) begin
      rd_ptr <= '0;
      count  <= commit_len;
      ready  <= (commit_len != '0);
    end else if (rd_fire) begin
      rd_ptr <= rd_ptr + CNT_W'(1);
      if (rd_ptr + CNT_W'(1) == count) ready <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ep0_irq_flags.sv
`timescale 1ns/1ps
module usb_ep0_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[g] <= 1'b0;
      else if (set[g]) flags[g] <= 1'b1;
      else if (clr[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_ep0_stage_fsm.sv
`timescale 1ns/1ps
module usb_ep0_stage_fsm
  import usb_ep0_pkg::*;
#(
  parameter int MAX_PKT = 8,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_setup,
  input  logic             tok_out,
  input  logic             tok_in,
  input  logic             rx_ack,
  input  logic             pkt_end,
  input  logic             pkt_pid1,
  input  logic             pkt_crc_ok,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             buf_ready,
  input  logic             cpu_setup_ack,
  input  logic             cpu_end,
  output logic             stg_gate,
  output logic             buf_gate,
  output logic             req_commit,
  output logic             buf_commit,
  output logic             buf_flush,
  output logic [IRQ_N-1:0] irq_set,
  output logic             hs_vld,
  output logic [1:0]       hs_kind
);
  stage_e st, st_nxt;
  tok_e   last_q;
  logic   acc_q;
  logic   exp_pid1_q, exp_nxt;
  logic   hs_set;
  hs_e    hs_k;
  logic   setup_ok, out_ok;

  assign setup_ok = pkt_crc_ok && !pkt_pid1 && (rx_len == CNT_W'(REQ_BYTES));
  assign out_ok   = pkt_crc_ok && (rx_len <= CNT_W'(MAX_PKT));
  assign stg_gate = (last_q == TK_SETUP) && (st == ST_SETUP_RX);
  assign buf_gate = (last_q == TK_OUT) && acc_q;

  always_comb begin
    st_nxt     = st;
    exp_nxt    = exp_pid1_q;
    hs_set     = 1'b0;
    hs_k       = HS_ACK;
    req_commit = 1'b0;
    buf_commit = 1'b0;
    buf_flush  = 1'b0;
    irq_set    = '0;
    if (tok_setup) begin
      st_nxt    = ST_SETUP_RX;
      buf_flush = 1'b1;
    end else begin
      if (tok_in) begin
        unique case (st)
          ST_WAIT_CPU: begin
            hs_set = 1'b1;
            hs_k   = HS_NAK;
          end
          ST_DATA: begin
            hs_set             = 1'b1;
            hs_k               = HS_NAK;
            irq_set[IRQ_EARLY] = 1'b1;
          end
          ST_STATUS, ST_ZLP_SENT: begin
            hs_set = 1'b1;
            hs_k   = HS_ZLP1;
            st_nxt = ST_ZLP_SENT;
          end
          default: ;
        endcase
      end else if (rx_ack) begin
        if (st == ST_ZLP_SENT) begin
          st_nxt            = ST_IDLE;
          irq_set[IRQ_STAT] = 1'b1;
        end
      end else if (pkt_end) begin
        if (last_q == TK_SETUP && st == ST_SETUP_RX && setup_ok) begin
          hs_set             = 1'b1;
          hs_k               = HS_ACK;
          req_commit         = 1'b1;
          irq_set[IRQ_SETUP] = 1'b1;
          st_nxt             = ST_WAIT_CPU;
          exp_nxt            = 1'b1;
        end else if (last_q == TK_OUT && out_ok) begin
          if (st == ST_WAIT_CPU) begin
            hs_set = 1'b1;
            hs_k   = HS_NAK;
          end else if (st == ST_DATA) begin
            hs_set = 1'b1;
            if (!acc_q) begin
              hs_k = HS_NAK;
            end else begin
              hs_k = HS_ACK;
              if (pkt_pid1 == exp_pid1_q) begin
                buf_commit = 1'b1;
                exp_nxt    = !exp_pid1_q;
              end
            end
          end
        end
      end
      if (cpu_setup_ack && st == ST_WAIT_CPU) st_nxt = ST_DATA;
      if (cpu_end && st == ST_DATA)           st_nxt = ST_STATUS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      last_q     <= TK_NONE;
      acc_q      <= 1'b0;
      exp_pid1_q <= 1'b0;
      hs_vld     <= 1'b0;
      hs_kind    <= HS_ACK;
    end else begin
      st         <= st_nxt;
      exp_pid1_q <= exp_nxt;
      hs_vld     <= hs_set;
      hs_kind    <= hs_k;
      if (tok_setup)               last_q <= TK_SETUP;
      else if (tok_out)            last_q <= TK_OUT;
      else if (tok_in || pkt_end)  last_q <= TK_NONE;
      if (tok_setup)    acc_q <= 1'b0;
      else if (tok_out) acc_q <= (st == ST_DATA) && !buf_ready;
    end
  end
endmodule

// File: rtl/usb_ep0_wr_seq.sv
`timescale 1ns/1ps
module usb_ep0_wr_seq
  import usb_ep0_pkg::*;
#(
  parameter int MAX_PKT = 8,
  parameter int CNT_W   = $clog2(MAX_PKT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_setup,
  input  logic             tok_out,
  input  logic             tok_in,
  input  logic             rx_ack,
  input  logic             rx_byte_vld,
  input  logic [7:0]       rx_byte,
  input  logic             rx_pkt_end,
  input  logic             rx_pid_data1,
  input  logic             rx_crc_ok,
  output logic             hs_vld,
  output logic [1:0]       hs_kind,
  output logic [2:0]       irq_flags,
  input  logic [2:0]       irq_clr,
  output logic [7:0]       req_type,
  output logic [7:0]       req_code,
  output logic [15:0]      req_value,
  output logic [15:0]      req_index,
  output logic [15:0]      req_length,
  input  logic             cpu_setup_ack,
  output logic             data_ready,
  output logic [CNT_W-1:0] data_count,
  input  logic             cpu_rd,
  output logic [7:0]       rd_data,
  input  logic             cpu_eop_wr,
  input  logic             cpu_eop_bit
);
  localparam logic [CNT_W-1:0] LEN_SAT = CNT_W'(MAX_PKT + 1);

  logic [CNT_W-1:0] rx_len;
  logic             stg_gate, buf_gate;
  logic             req_commit, buf_commit, buf_flush;
  logic [IRQ_N-1:0] irq_set;
  req_t             req;

  always_ff @(posedge clk) begin
    if (rst)                                 rx_len <= '0;
    else if (tok_setup || tok_out)           rx_len <= '0;
    else if (rx_byte_vld && rx_len != LEN_SAT) rx_len <= rx_len + CNT_W'(1);
  end

  usb_ep0_stage_fsm #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .tok_setup    (tok_setup),
    .tok_out      (tok_out),
    .tok_in       (tok_in),
    .rx_ack       (rx_ack),
    .pkt_end      (rx_pkt_end),
    .pkt_pid1     (rx_pid_data1),
    .pkt_crc_ok   (rx_crc_ok),
    .rx_len       (rx_len),
    .buf_ready    (data_ready),
    .cpu_setup_ack(cpu_setup_ack),
    .cpu_end      (cpu_eop_wr && !cpu_eop_bit),
    .stg_gate     (stg_gate),
    .buf_gate     (buf_gate),
    .req_commit   (req_commit),
    .buf_commit   (buf_commit),
    .buf_flush    (buf_flush),
    .irq_set      (irq_set),
    .hs_vld       (hs_vld),
    .hs_kind      (hs_kind)
  );

  usb_ep0_req_capture #(.CNT_W(CNT_W)) u_req (
    .clk     (clk),
    .rst     (rst),
    .byte_we (rx_byte_vld && stg_gate),
    .byte_idx(rx_len),
    .byte_in (rx_byte),
    .commit  (req_commit),
    .req     (req)
  );

  usb_ep0_rx_buffer #(.DEPTH(MAX_PKT), .CNT_W(CNT_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (buf_flush),
    .wr_en     (rx_byte_vld && buf_gate),
    .wr_idx    (rx_len),
    .wr_byte   (rx_byte),
    .commit    (buf_commit),
    .commit_len(rx_len),
    .rd_req    (cpu_rd),
    .rd_data   (rd_data),
    .ready     (data_ready),
    .count     (data_count)
  );

  usb_ep0_irq_flags #(.N(IRQ_N)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .set  (irq_set),
    .clr  (irq_clr),
    .flags(irq_flags)
  );

  assign req_type   = req.rtype;
  assign req_code   = req.code;
  assign req_value  = req.value;
  assign req_index  = req.index;
  assign req_length = req.length;
endmodule

// File: rtl/usb_ep0_wr_seq_chk.sv
`timescale 1ns/1ps
module usb_ep0_wr_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tok_setup,
  input logic             tok_in,
  input logic             rx_pkt_end,
  input logic             rx_crc_ok,
  input logic             hs_vld,
  input logic [1:0]       hs_kind,
  input logic [2:0]       irq_flags,
  input logic [2:0]       irq_clr,
  input logic             data_ready,
  input logic [CNT_W-1:0] data_count
);
  a_r12_setup_hold: assert property (@(posedge clk) disable iff (rst)
    irq_flags[0] && !irq_clr[0] |=> irq_flags[0]);
  a_r12_status_hold: assert property (@(posedge clk) disable iff (rst)
    irq_flags[1] && !irq_clr[1] |=> irq_flags[1]);
  a_r12_early_hold: assert property (@(posedge clk) disable iff (rst)
    irq_flags[2] && !irq_clr[2] |=> irq_flags[2]);
  a_r13_ready_nonempty: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> data_count != '0);
  a_r10_zlp_after_in: assert property (@(posedge clk) disable iff (rst)
    hs_vld && hs_kind == 2'd2 |-> $past(tok_in));
  a_r2_ack_after_pkt: assert property (@(posedge clk) disable iff (rst)
    hs_vld && hs_kind == 2'd0 |-> $past(rx_pkt_end));
  a_r11_setup_flush: assert property (@(posedge clk) disable iff (rst)
    tok_setup |=> !data_ready && data_count == '0);
  a_r3_crc_silent: assert property (@(posedge clk) disable iff (rst)
    rx_pkt_end && !rx_crc_ok && !tok_in |=> !hs_vld);
endmodule

bind usb_ep0_wr_seq usb_ep0_wr_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/usb_ep0_wr_seq_tb.sv
`timescale 1ns/1ps
module usb_ep0_wr_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_setup = 0, tok_out = 0, tok_in = 0, rx_ack = 0;
  logic rx_byte_vld = 0, rx_pkt_end = 0, rx_pid_data1 = 0, rx_crc_ok = 0;
  logic [7:0] rx_byte = '0;
  logic [2:0] irq_clr = '0;
  logic cpu_setup_ack = 0, cpu_rd = 0, cpu_eop_wr = 0, cpu_eop_bit = 0;
  logic hs_vld, data_ready;
  logic [1:0] hs_kind;
  logic [2:0] irq_flags;
  logic [7:0] req_type, req_code, rd_data;
  logic [15:0] req_value, req_index, req_length;
  logic [3:0] data_count;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0;

  always #2.5 clk = ~clk;

  usb_ep0_wr_seq u_dut (.*);

  // behavioural reference model
  int st = 0, last = 0, len = 0;
  bit acc = 0, exp1 = 0;
  logic [7:0] stg [8];
  logic [7:0] pk[$], fq[$];
  logic [63:0] e_req = '0;
  bit e_hsv = 0, e_rdy = 0;
  int e_hsk = 0, e_cnt = 0;
  logic [2:0] e_irq = '0;
  logic [7:0] e_rd = '0;

  always @(posedge clk) begin
    int o_st, o_last, o_len;
    bit o_rdy;
    logic [2:0] s;
    started <= 1;
    if (rst) begin
      st = 0; last = 0; len = 0; acc = 0; exp1 = 0;
      pk.delete(); fq.delete();
      e_req = '0; e_hsv = 0; e_hsk = 0; e_rdy = 0; e_cnt = 0; e_irq = '0; e_rd = '0;
    end else begin
      o_st = st; o_last = last; o_len = len; o_rdy = e_rdy;
      e_hsv = 0; s = '0;
      if (tok_setup) begin
        st = 1; last = 1; len = 0; acc = 0;
        fq.delete(); pk.delete(); e_rdy = 0; e_cnt = 0;
      end else begin
        if (tok_out) begin
          last = 2; len = 0; pk.delete();
          acc = (o_st == 3) && !o_rdy;
        end
        if (tok_in) begin
          last = 0;
          if (o_st == 2) begin e_hsv = 1; e_hsk = 1; end
          else if (o_st == 3) begin e_hsv = 1; e_hsk = 1; s[2] = 1; end
          else if (o_st == 4 || o_st == 5) begin e_hsv = 1; e_hsk = 2; st = 5; end
        end
        if (rx_ack && o_st == 5) begin st = 0; s[1] = 1; end
        if (rx_byte_vld) begin
          if (o_last == 1 && o_st == 1 && o_len < 8) stg[o_len] = rx_byte;
          if (o_last == 2 && pk.size() < 9) pk.push_back(rx_byte);
          if (len < 9) len++;
        end
        if (rx_pkt_end) begin
          last = 0;
          if (o_last == 1 && o_st == 1 && rx_crc_ok && o_len == 8 && !rx_pid_data1) begin
            e_hsv = 1; e_hsk = 0; s[0] = 1; st = 2; exp1 = 1;
            for (int i = 0; i < 8; i++) e_req[8*i +: 8] = stg[i];
          end else if (o_last == 2 && rx_crc_ok && o_len <= 8) begin
            if (o_st == 2) begin e_hsv = 1; e_hsk = 1; end
            else if (o_st == 3) begin
              e_hsv = 1;
              if (!acc) e_hsk = 1;
              else begin
                e_hsk = 0;
                if (rx_pid_data1 == exp1) begin
                  fq = pk; e_cnt = o_len; e_rdy = (o_len != 0); exp1 = !exp1;
                end
              end
            end
          end
        end
        if (cpu_setup_ack && o_st == 2) st = 3;
        if (cpu_eop_wr && !cpu_eop_bit && o_st == 3) st = 4;
        if (cpu_rd && o_rdy) begin
          e_rd = fq.pop_front();
          if (fq.size() == 0) e_rdy = 0;
        end
      end
      for (int k = 0; k < 3; k++) begin
        if (s[k]) e_irq[k] = 1'b1;
        else if (irq_clr[k]) e_irq[k] = 1'b0;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("hs_vld", 32'(hs_vld), 32'(e_hsv));
      if (e_hsv) chk("hs_kind", 32'(hs_kind), 32'(e_hsk));
      chk("irq_flags", 32'(irq_flags), 32'(e_irq));
      chk("data_ready", 32'(data_ready), 32'(e_rdy));
      chk("data_count", 32'(data_count), 32'(e_cnt));
      chk("req_lo", {req_value, req_code, req_type}, e_req[31:0]);
      chk("req_hi", {req_length, req_index}, e_req[63:32]);
      chk("rd_data", 32'(rd_data), 32'(e_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_setup(input logic [63:0] r, input int nb, input bit pid1, input bit crc);
    @(negedge clk) tok_setup = 1;
    @(negedge clk) tok_setup = 0;
    for (int i = 0; i < nb; i++) begin
      rx_byte_vld = 1; rx_byte = (i < 8) ? r[8*i +: 8] : 8'hEE;
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_pkt_end = 1; rx_pid_data1 = pid1; rx_crc_ok = crc;
    @(negedge clk) rx_pkt_end = 0;
    idle(2);
  endtask

  task automatic send_out(input int nb, input logic [7:0] seed, input bit pid1, input bit crc);
    @(negedge clk) tok_out = 1;
    @(negedge clk) tok_out = 0;
    for (int i = 0; i < nb; i++) begin
      rx_byte_vld = 1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_pkt_end = 1; rx_pid_data1 = pid1; rx_crc_ok = crc;
    @(negedge clk) rx_pkt_end = 0;
    idle(2);
  endtask

  task automatic send_in;
    @(negedge clk) tok_in = 1;
    @(negedge clk) tok_in = 0;
    idle(2);
  endtask

  task automatic host_ack;
    @(negedge clk) rx_ack = 1;
    @(negedge clk) rx_ack = 0;
    idle(2);
  endtask

  task automatic setup_ack;
    @(negedge clk) cpu_setup_ack = 1;
    @(negedge clk) cpu_setup_ack = 0;
    idle(1);
  endtask

  task automatic rd_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cpu_rd = 1;
    end
    @(negedge clk) cpu_rd = 0;
    idle(1);
  endtask

  task automatic eop(input bit b);
    @(negedge clk) begin cpu_eop_wr = 1; cpu_eop_bit = b; end
    @(negedge clk) cpu_eop_wr = 0;
    idle(1);
  endtask

  task automatic clr_irq(input logic [2:0] m);
    @(negedge clk) irq_clr = m;
    @(negedge clk) irq_clr = '0;
    idle(1);
  endtask

  initial begin
    idle(4);
    cur_req = "R1"; rst = 0;
    idle(3);

    cur_req = "R3";
    send_setup(64'h0010_0000_0000_0921, 8, 0, 0);
    send_setup(64'h0010_0000_0000_0921, 7, 0, 1);
    send_setup(64'h0010_0000_0000_0921, 8, 1, 1);
    send_in;

    cur_req = "R2";
    send_setup(64'h0018_0004_0302_0921, 8, 0, 1);
    cur_req = "R12";
    clr_irq(3'b001);

    cur_req = "R4";
    send_out(4, 8'h10, 1, 1);
    send_in;
    setup_ack;

    cur_req = "R5";
    send_out(5, 8'h20, 1, 1);
    cur_req = "R6";
    send_out(3, 8'h40, 0, 1);
    cur_req = "R5";
    rd_bytes(5);
    cur_req = "R7";
    send_out(6, 8'h50, 1, 1);
    cur_req = "R5";
    send_out(8, 8'h60, 0, 1);
    rd_bytes(7);
    cur_req = "R6";
    @(negedge clk) begin cpu_rd = 1; tok_out = 1; end
    @(negedge clk) begin cpu_rd = 0; tok_out = 0; end
    for (int i = 0; i < 4; i++) begin
      rx_byte_vld = 1; rx_byte = 8'h70 + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_pkt_end = 1; rx_pid_data1 = 1; rx_crc_ok = 1;
    @(negedge clk) rx_pkt_end = 0;
    idle(2);
    cur_req = "R3";
    send_out(9, 8'h80, 1, 1);
    send_out(2, 8'h90, 1, 0);
    cur_req = "R13";
    send_out(0, 8'h00, 1, 1);
    send_out(3, 8'hA0, 0, 1);
    rd_bytes(3);

    cur_req = "R8";
    send_in;
    cur_req = "R12";
    clr_irq(3'b100);
    @(negedge clk) begin tok_in = 1; irq_clr = 3'b100; end
    @(negedge clk) begin tok_in = 0; irq_clr = '0; end
    idle(2);

    cur_req = "R9";
    eop(1);
    send_in;
    eop(0);
    cur_req = "R10";
    send_in;
    send_in;
    host_ack;
    send_in;
    clr_irq(3'b111);

    cur_req = "R11";
    send_setup(64'h0008_0000_0000_0521, 8, 0, 1);
    setup_ack;
    send_out(4, 8'hB0, 1, 1);
    send_setup(64'h0002_0001_0007_0340, 8, 0, 1);
    setup_ack;
    send_out(2, 8'hC0, 1, 1);
    rd_bytes(2);
    eop(0);
    send_in;
    host_ack;
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule